// File: doc/BRIEF.md
# Indexed Audio Codec Register File

This block is the host-facing register front end of an audio codec. The host reaches it through four byte-wide direct ports, selected by a 2-bit address with separate write and read strobes. One port holds an index pointer. A second port reads and writes whichever of 32 indirect control registers that pointer selects. A third port carries the interrupt status, and the fourth is a programmed-I/O data port that this block leaves inert.

The indirect bank enforces the codec's access rules. Some registers are read-only or reserved. One register has a single writable bit, and one has a bit that is always written as zero. Writes to the sample rate/format register only land while a mode-change window is open. A partial-change enable lets the host alter only the upper nibble of that register. The pointer reaches 16 registers in the default narrow mode and all 32 once a wide-mode bit is set.

Opening the mode-change window with the calibration select bits nonzero starts a short calibration period. During that period the read-only error/init register reports a busy bit for a parameterised number of reads. The playback engine raises an interrupt through a set input. The block sends a one-cycle update pulse back to that engine whenever the format or the interface configuration register changes.

Top module: `acr_regfile`

## Requirements
- R1: After reset the pointer port reads 0x40 and the indirect registers hold: 0x88 at 2, 3, 4, 5, 18, 19; 0x80 at 6, 7; 0x08 at 9; 0x8A at 12; 0xA0 at 25, 26; 0x00 everywhere else. The interrupt and update outputs are low.
- R2: Direct port 0 (pointer) stores the written byte with bit 7 cleared and reads back the stored value, whose bit 7 is always 0.
- R3: Direct port 1 accesses the indirect register selected by pointer bits 3:0, or by bits 4:0 when bit 6 of register 12 is 1. Ordinary registers store the full written byte.
- R4: Data-port writes to registers 11, 22, 27 and 29 leave them unchanged.
- R5: A write to register 12 changes only its bit 6. A write to register 9 stores the byte with bit 5 forced to 0.
- R6: A write to register 8 is stored whole when pointer bit 6 is 1. Otherwise, when register 24 bit 4 is 1, only bits 7:4 are taken and bits 3:0 are kept. Otherwise the write is dropped.
- R7: A pointer write that takes pointer bit 6 from 0 to 1 while register 9 bits 4:3 are nonzero loads a counter with CAL_RELOAD (default 1). While the counter is nonzero, each data-port read of register 11 returns bit 5 set and decrements the counter. Other reads leave the counter unchanged.
- R8: Any write to direct port 2 clears the interrupt (status bit 0) and register 24 bits 6:4. A register 24 write that takes its bit 4 from 1 to 0 also clears the interrupt.
- R9: Writes to direct port 3 change nothing. Port 3 reads 0x00, and port 2 reads the interrupt flag in bit 0 with 0 in bits 7:1.
- R10: `irq_o` equals status bit 0. `pb_done_i` sets status bit 0 and register 24 bit 4 at the next edge, and it wins over a clear in the same cycle.
- R11: `cfg_upd_o` pulses high for one cycle after a data-port write to register 9, or after a register 8 write that R6 accepts. It stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Direct port select: 0 pointer, 1 data, 2 status, 3 PIO |
| wr_i | input | 1 | Write strobe, one byte per cycle |
| rd_i | input | 1 | Read strobe; read side effects occur at the edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for addr_i |
| pb_done_i | input | 1 | Interrupt set from the playback engine |
| irq_o | output | 1 | Interrupt request (status bit 0) |
| cfg_upd_o | output | 1 | One-cycle pulse after a format or configuration update |

## Verification
The assertions check the following on every cycle: the pointer read's bit 7, the PIO read value, the set-then-clear behaviour of the interrupt, the interrupt holding steady when there is no host write or set, the busy bit on calibrated reads of register 11, and the update pulse arising only from a data-port write. The bench's scenarios are needed for everything else. That covers the reset contents of all 32 registers, aliasing of the index in narrow mode, and the write masks of registers 9 and 12. It also covers the three-way gating of register 8, the exact number of reads for which the calibration flag lasts, and a set and a clear arriving in the same cycle. All of these are compared against a model written from the requirements.

// File: rtl/acr_pkg.sv
package acr_pkg;
  localparam int unsigned DW      = 8;
  localparam int unsigned NREG    = 32;
  localparam int unsigned IW      = $clog2(NREG);
  localparam int unsigned IX_FMT  = 8;
  localparam int unsigned IX_CFG  = 9;
  localparam int unsigned IX_ERR  = 11;
  localparam int unsigned IX_MODE = 12;
  localparam int unsigned IX_ALT  = 24;

  typedef enum logic [1:0] {
    PORT_IDX  = 2'd0,
    PORT_DATA = 2'd1,
    PORT_STAT = 2'd2,
    PORT_PIO  = 2'd3
  } port_e;

  function automatic logic [DW-1:0] reg_rst(int unsigned i);
    case (i)
      2, 3, 4, 5, 18, 19: return 8'h88;
      6, 7:               return 8'h80;
      9:                  return 8'h08;
      12:                 return 8'h8A;
      25, 26:             return 8'hA0;
      default:            return 8'h00;
    endcase
  endfunction

  function automatic logic reg_locked(int unsigned i);
    return (i == 11) || (i == 22) || (i == 27) || (i == 29);
  endfunction
endpackage

// File: rtl/acr_index.sv
module acr_index
  import acr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wide_i,
  output logic [DW-1:0] idx_o,
  output logic [IW-1:0] sel_o,
  output logic          chg_en_o,
  output logic          chg_rise_o
);
  logic [DW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   idx_q <= 8'h40;
    else if (wr_i) idx_q <= {1'b0, wdata_i[6:0]};
  end

  assign idx_o      = idx_q;
  assign sel_o      = wide_i ? idx_q[IW-1:0] : {1'b0, idx_q[IW-2:0]};
  assign chg_en_o   = idx_q[6];
  assign chg_rise_o = wr_i && wdata_i[6] && !idx_q[6];
endmodule

// File: rtl/acr_bank.sv
module acr_bank
  import acr_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [IW-1:0]           sel_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic                    chg_en_i,
  input  logic                    ack_all_i,
  input  logic                    pb_set_i,
  output logic [NREG-1:0][DW-1:0] regs_o,
  output logic                    fmt_acc_o,
  output logic                    alt_fall_o
);
  logic [DW-1:0] r_q [NREG];
  logic          part_en;

  assign part_en    = r_q[IX_ALT][4];
  assign fmt_acc_o  = wr_i && (int'(sel_i) == IX_FMT) && (chg_en_i || part_en);
  assign alt_fall_o = wr_i && (int'(sel_i) == IX_ALT) && part_en && !wdata_i[4];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit;
    assign hit = wr_i && (int'(sel_i) == g);

    if (reg_locked(g)) begin : g_ro
      assign r_q[g] = reg_rst(g);
    end else if (g == IX_FMT) begin : g_fmt
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                r_q[g] <= reg_rst(g);
        else if (hit && chg_en_i)   r_q[g] <= wdata_i;
        else if (hit && part_en)    r_q[g] <= {wdata_i[7:4], r_q[g][3:0]};
      end
    end else if (g == IX_CFG) begin : g_cfg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  r_q[g] <= reg_rst(g);
        else if (hit) r_q[g] <= wdata_i & 8'hDF;
      end
    end else if (g == IX_MODE) begin : g_mode
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  r_q[g] <= reg_rst(g);
        else if (hit) r_q[g] <= {r_q[g][7], wdata_i[6], r_q[g][5:0]};
      end
    end else if (g == IX_ALT) begin : g_alt
      logic [DW-1:0] nxt;
      always_comb begin
        nxt = r_q[g];
        if (hit)       nxt = wdata_i;
        if (ack_all_i) nxt[6:4] = 3'b000;
        if (pb_set_i)  nxt[4] = 1'b1;
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q[g] <= reg_rst(g);
        else         r_q[g] <= nxt;
      end
    end else begin : g_rw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  r_q[g] <= reg_rst(g);
        else if (hit) r_q[g] <= wdata_i;
      end
    end

    assign regs_o[g] = r_q[g];
  end
endmodule

// File: rtl/acr_cal.sv
module acr_cal #(
  parameter int unsigned CAL_RELOAD = 1,
  localparam int unsigned CW = $clog2(CAL_RELOAD + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic dec_i,
  output logic busy_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= CW'(CAL_RELOAD);
    else if (dec_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/acr_irq.sv
module acr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic int_o
);
  logic int_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    int_q <= 1'b0;
    else if (set_i) int_q <= 1'b1;
    else if (clr_i) int_q <= 1'b0;
  end

  assign int_o = int_q;
endmodule

// File: rtl/acr_regfile.sv
module acr_regfile
  import acr_pkg::*;
#(
  parameter int unsigned CAL_RELOAD = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       pb_done_i,
  output logic       irq_o,
  output logic       cfg_upd_o
);
  logic                    wr_idx, wr_data, wr_stat, rd_data;
  logic [DW-1:0]           idx_q;
  logic [IW-1:0]           sel;
  logic                    chg_en, chg_rise;
  logic [NREG-1:0][DW-1:0] regs;
  logic                    fmt_acc, alt_fall;
  logic                    cal_busy, int_q;
  logic                    upd_q;

  assign wr_idx  = wr_i && (addr_i == PORT_IDX);
  assign wr_data = wr_i && (addr_i == PORT_DATA);
  assign wr_stat = wr_i && (addr_i == PORT_STAT);
  assign rd_data = rd_i && (addr_i == PORT_DATA);

  acr_index i_index (
    .clk_i, .rst_ni,
    .wr_i      (wr_idx),
    .wdata_i,
    .wide_i    (regs[IX_MODE][6]),
    .idx_o     (idx_q),
    .sel_o     (sel),
    .chg_en_o  (chg_en),
    .chg_rise_o(chg_rise)
  );

  acr_bank i_bank (
    .clk_i, .rst_ni,
    .wr_i      (wr_data),
    .sel_i     (sel),
    .wdata_i,
    .chg_en_i  (chg_en),
    .ack_all_i (wr_stat),
    .pb_set_i  (pb_done_i),
    .regs_o    (regs),
    .fmt_acc_o (fmt_acc),
    .alt_fall_o(alt_fall)
  );

  acr_cal #(.CAL_RELOAD(CAL_RELOAD)) i_cal (
    .clk_i, .rst_ni,
    .load_i(chg_rise && (regs[IX_CFG][4:3] != 2'b00)),
    .dec_i (rd_data && (int'(sel) == IX_ERR)),
    .busy_o(cal_busy)
  );

  acr_irq i_irq (
    .clk_i, .rst_ni,
    .set_i(pb_done_i),
    .clr_i(wr_stat || alt_fall),
    .int_o(int_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upd_q <= 1'b0;
    else         upd_q <= fmt_acc || (wr_data && (int'(sel) == IX_CFG));
  end

  always_comb begin
    case (addr_i)
      PORT_IDX:  rdata_o = idx_q;
      PORT_DATA: begin
        rdata_o = regs[sel];
        if (int'(sel) == IX_ERR && cal_busy) rdata_o[5] = 1'b1;
      end
      PORT_STAT: rdata_o = {7'b0, int_q};
      default:   rdata_o = 8'h00;
    endcase
  end

  assign irq_o     = int_q;
  assign cfg_upd_o = upd_q;
endmodule

// File: rtl/acr_chk.sv
module acr_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] addr_i,
  input logic       wr_i,
  input logic       rd_i,
  input logic [7:0] rdata_o,
  input logic       pb_done_i,
  input logic       irq_o,
  input logic       cfg_upd_o,
  input logic [4:0] sel,
  input logic       cal_busy
);
  a_r2_idx_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 2'd0) |-> !rdata_o[7]);

  a_r9_pio_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 2'd3) |-> (rdata_o == 8'h00));

  a_r10_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pb_done_i |=> irq_o);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pb_done_i && !wr_i) |=> $stable(irq_o));

  a_r8_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd2 && !pb_done_i) |=> !irq_o);

  a_r7_cal_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cal_busy && rd_i && addr_i == 2'd1 && sel == 5'd11) |-> rdata_o[5]);

  a_r11_upd_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_upd_o |-> ($past(wr_i) && $past(addr_i) == 2'd1));
endmodule

bind acr_regfile acr_chk i_acr_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .rdata_o  (rdata_o),
  .pb_done_i(pb_done_i),
  .irq_o    (irq_o),
  .cfg_upd_o(cfg_upd_o),
  .sel      (sel),
  .cal_busy (cal_busy)
);

// File: tb/test_acr_regfile.sv
module test_acr_regfile;
  localparam int CAL = 1;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr_i = '0;
  logic       wr_i = 1'b0, rd_i = 1'b0, pb_done_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o, cfg_upd_o;

  int errors = 0, checks = 0;

  logic [7:0] m_reg [32];
  logic [7:0] m_idx;
  logic       m_int;
  int         m_cal;

  always #5 clk_i = ~clk_i;

  acr_regfile #(.CAL_RELOAD(CAL)) i_acr_regfile (.*);

  function automatic logic [7:0] rst_val(int i);
    case (i)
      2, 3, 4, 5, 18, 19: return 8'h88;
      6, 7:               return 8'h80;
      9:                  return 8'h08;
      12:                 return 8'h8A;
      25, 26:             return 8'hA0;
      default:            return 8'h00;
    endcase
  endfunction

  function automatic int eff();
    return m_reg[12][6] ? int'(m_idx[4:0]) : int'(m_idx[3:0]);
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d, input bit pb = 0);
    bit exp_upd = 0;
    int e;
    case (a)
      2'd0: begin
        if (d[6] && !m_idx[6] && m_reg[9][4:3] != 2'b00) m_cal = CAL;
        m_idx = {1'b0, d[6:0]};
      end
      2'd1: begin
        e = eff();
        case (e)
          11, 22, 27, 29: ;
          12: m_reg[12][6] = d[6];
          9: begin m_reg[9] = d & 8'hDF; exp_upd = 1; end
          8: begin
            if (m_idx[6]) begin m_reg[8] = d; exp_upd = 1; end
            else if (m_reg[24][4]) begin m_reg[8] = {d[7:4], m_reg[8][3:0]}; exp_upd = 1; end
          end
          24: begin
            if (m_reg[24][4] && !d[4]) m_int = 0;
            m_reg[24] = d;
          end
          default: m_reg[e] = d;
        endcase
      end
      2'd2: begin m_int = 0; m_reg[24][6:4] = 3'b000; end
      default: ;
    endcase
    if (pb) begin m_int = 1; m_reg[24][4] = 1'b1; end
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1; pb_done_i = pb;
    @(posedge clk_i); #1;
    wr_i = 1'b0; pb_done_i = 1'b0;
    check({7'b0, cfg_upd_o}, {7'b0, exp_upd}, "R11 update pulse");
    check({7'b0, irq_o}, {7'b0, m_int}, "R10 irq level");
  endtask

  task automatic pb_pulse();
    m_int = 1; m_reg[24][4] = 1'b1;
    @(negedge clk_i); pb_done_i = 1'b1;
    @(posedge clk_i); #1; pb_done_i = 1'b0;
    check({7'b0, irq_o}, 8'h01, "R10 set by engine");
  endtask

  task automatic host_rd(input logic [1:0] a, input string tag);
    logic [7:0] exp;
    int e;
    e = eff();
    case (a)
      2'd0: exp = m_idx;
      2'd1: begin
        exp = m_reg[e];
        if (e == 11 && m_cal != 0) exp[5] = 1'b1;
      end
      2'd2: exp = {7'b0, m_int};
      default: exp = 8'h00;
    endcase
    @(negedge clk_i); addr_i = a; rd_i = 1'b1;
    #2 check(rdata_o, exp, tag);
    @(posedge clk_i); #1; rd_i = 1'b0;
    if (a == 2'd1 && e == 11 && m_cal != 0) m_cal--;
  endtask

  task automatic rd_ind(input logic [7:0] ix, input string tag);
    host_wr(2'd0, ix);
    host_rd(2'd1, tag);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) m_reg[i] = rst_val(i);
    m_idx = 8'h40; m_int = 0; m_cal = 0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    check({6'b0, irq_o, cfg_upd_o}, 8'h00, "R1 outputs after reset");
    host_rd(2'd0, "R1 pointer reset");
    for (int i = 0; i < 16; i++) rd_ind(8'(i), "R1 narrow reset value");

    // R2: bit 7 dropped
    host_wr(2'd0, 8'hFF);
    host_rd(2'd0, "R2 pointer msb");
    host_wr(2'd0, 8'h80);
    host_rd(2'd0, "R2 pointer msb");

    // R3: narrow aliasing, then wide mode via R5 register 12
    rd_ind(8'h13, "R3 narrow alias");
    host_wr(2'd0, 8'h0C); host_wr(2'd1, 8'hFF);
    host_rd(2'd1, "R5 mode reg mask");
    for (int i = 16; i < 32; i++) rd_ind(8'(i), "R1 wide reset value");
    rd_ind(8'h13, "R3 wide select");

    // sweep every register with a distinct pattern, pointer bit 6 held
    for (int i = 0; i < 32; i++) begin
      string tag;
      if (i == 12) continue;
      tag = (i == 11 || i == 22 || i == 27 || i == 29) ? "R4 protected" :
            (i == 9) ? "R5 cfg bit5" : (i == 8) ? "R6 format" :
            (i == 24) ? "R8 alt reg" : "R3 readback";
      host_wr(2'd0, 8'(i) | 8'h40);
      host_wr(2'd1, 8'((i * 53 + 8'h2B) & 8'hFF));
      host_rd(2'd1, tag);
    end
    for (int i = 0; i < 32; i++) rd_ind(8'(i) | 8'h40, "R4 bank after sweep");

    // R6 gating
    host_wr(2'd0, 8'h18); host_wr(2'd1, 8'h00);
    host_wr(2'd0, 8'h08); host_wr(2'd1, 8'h5A);
    host_rd(2'd1, "R6 dropped");
    host_wr(2'd0, 8'h18); host_wr(2'd1, 8'h10);
    host_wr(2'd0, 8'h08); host_wr(2'd1, 8'hC3);
    host_rd(2'd1, "R6 partial");
    host_wr(2'd0, 8'h48); host_wr(2'd1, 8'h77);
    host_rd(2'd1, "R6 full");

    // R7 calibration flag
    host_wr(2'd0, 8'h09); host_wr(2'd1, 8'h00);
    host_wr(2'd0, 8'h0B);
    repeat (3) host_rd(2'd1, "R7 drain");
    host_wr(2'd0, 8'h4B);
    host_rd(2'd1, "R7 no load when cal bits zero");
    host_wr(2'd0, 8'h09); host_wr(2'd1, 8'h18);
    host_wr(2'd0, 8'h0B); host_wr(2'd0, 8'h4B);
    host_rd(2'd1, "R7 flag set");
    host_rd(2'd1, "R7 flag expired");
    host_wr(2'd0, 8'h0A); host_wr(2'd0, 8'h4A);
    host_rd(2'd1, "R7 other read keeps count");
    host_wr(2'd0, 8'h4B);
    host_rd(2'd1, "R7 flag after other read");
    host_rd(2'd1, "R7 flag expired again");

    // R8 / R10 interrupt
    host_wr(2'd2, 8'h00);
    host_rd(2'd2, "R9 status clear");
    pb_pulse();
    host_rd(2'd2, "R9 status set");
    rd_ind(8'h58, "R10 alt bit4 set");
    host_wr(2'd2, 8'hFF);
    host_rd(2'd2, "R8 status ack");
    rd_ind(8'h58, "R8 alt bits cleared");
    pb_pulse();
    host_wr(2'd0, 8'h58); host_wr(2'd1, 8'h60);
    host_rd(2'd2, "R8 alt fall ack");
    pb_pulse();
    host_wr(2'd2, 8'h00, 1);
    host_rd(2'd2, "R10 set wins");
    rd_ind(8'h58, "R10 set wins alt");

    // R9 PIO port
    host_wr(2'd3, 8'hFF);
    host_rd(2'd3, "R9 pio read");
    host_rd(2'd0, "R9 pointer after pio");
    host_rd(2'd2, "R9 status after pio");
    for (int i = 0; i < 32; i++) rd_ind(8'(i) | 8'h40, "R9 bank after pio");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule